// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block produces the pixel-rate timing for an image output path. It runs from one fast reference clock `clk` whose rate is twice the master clock. Each `clk` cycle therefore stands for half a master-clock period, which is called a half-step below. The block does not generate a new clock net. It produces a registered pixel-clock level, a one-cycle enable on each rising edge of that level, and a one-cycle data-launch strobe. Downstream logic uses these as enables in the `clk` domain.

An optional divide-by-two stage halves the half-step rate. A 4-bit speed field sets the pixel period to twice its value in half-steps, with 50% duty. A 4-bit delay field makes the pixel-clock level lag the data-launch timing by 0 to 15 half-steps. A stop input holds every generated output low and freezes the internal state. New speed and delay values are taken only at a period boundary.

Top module: `pcg_pixclk_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `launch_stb`, `pclk_dly` and `pclk_en` are low. The first half-step after reset release opens a new period and raises `launch_stb`.
- R2: With effective speed S, a pixel period lasts 2*S half-steps. `launch_stb` is high for exactly one `clk` cycle, in the cycle that opens each period.
- R3: A speed field of 0 behaves exactly as a speed field of 1.
- R4: `pclk_dly` follows a reference level that is high for the first S half-steps of each period and low for the last S half-steps. It lags that level by D half-steps, where D is the delay field (0 to 15). With D = 0, `pclk_dly` rises in the same cycle as `launch_stb`. Half-steps before the first period count as low.
- R5: `pclk_en` is high for one cycle exactly when `pclk_dly` goes from low to high.
- R6: With `div2` low, every `clk` cycle is a half-step. With `div2` high, every second `clk` cycle is a half-step, and outputs change only on half-steps.
- R7: A cycle with `stop` sampled high drives all three outputs low and freezes the period position and the divider. After `stop` falls, the period resumes where it was frozen.
- R8: Speed and delay values are sampled only in the cycle that opens a period. A change made mid-period does not alter the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| div2 | input | 1 | Halve the half-step rate |
| speed | input | 4 | Pixel period multiple; 0 treated as 1 |
| delay | input | 4 | Pixel-clock lag in half-steps |
| stop | input | 1 | Hold all generated outputs off |
| pclk_en | output | 1 | One-cycle enable at each delayed pixel-clock rise |
| pclk_dly | output | 1 | Delayed pixel-clock level |
| launch_stb | output | 1 | One-cycle data-launch strobe at period start |

## Verification
A wrong phase count or a wrong latched speed shows up as a gap between `launch_stb` pulses that differs from 2*S half-steps, within one period. A corrupted delay line or a wrong tap shows up as `pclk_dly` edges offset from the launch strobe by a count other than D. This appears no later than D half-steps after the next boundary. A divider or stop fault changes the strobe spacing in the very next cycle. The bench therefore compares every output in every cycle against a reference derived from the requirements, and also measures strobe spacing directly.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int SPD_W = 4;
  localparam int DLY_W = 4;

  function automatic logic [SPD_W-1:0] eff_speed(input logic [SPD_W-1:0] s);
    return (s == '0) ? SPD_W'(1) : s;
  endfunction
endpackage

// File: rtl/pcg_halfstep.sv
module pcg_halfstep (
  input  logic clk,
  input  logic rst,
  input  logic div2,
  input  logic stop,
  output logic step
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst)        tog_q <= 1'b0;
    else if (!stop) tog_q <= div2 ? ~tog_q : 1'b0;
  end

  assign step = !stop && (div2 ? tog_q : 1'b1);
endmodule

// File: rtl/pcg_phase.sv
module pcg_phase #(
  parameter int SPD_W = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SPD_W-1:0] spd_in,
  input  logic [DLY_W-1:0] dly_in,
  output logic             bound,
  output logic             lvl_next,
  output logic [DLY_W-1:0] dly_next,
  output logic [DLY_W-1:0] dly_cur
);
  import pcg_pkg::*;
  localparam int PH_W = SPD_W + 1;

  logic [PH_W-1:0]  ph_q, ph_n, last_ph;
  logic [SPD_W-1:0] spd_q, spd_n;
  logic             pend_q;

  assign last_ph  = {spd_q, 1'b0} - PH_W'(1);
  assign bound    = step && (pend_q || ph_q == last_ph);
  assign ph_n     = bound ? '0 : ph_q + PH_W'(1);
  assign spd_n    = bound ? eff_speed(spd_in) : spd_q;
  assign dly_next = bound ? dly_in : dly_cur;
  assign lvl_next = ph_n < PH_W'(spd_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      spd_q   <= SPD_W'(1);
      dly_cur <= DLY_W'(1);
      pend_q  <= 1'b1;
    end else if (step) begin
      ph_q    <= ph_n;
      spd_q   <= spd_n;
      dly_cur <= dly_next;
      pend_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcg_delay_line.sv
module pcg_delay_line #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  input  logic [DLY_W-1:0] sel,
  output logic             tap
);
  localparam int DEPTH = 2 ** DLY_W;

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_n;

  assign line_n[0] = din;
  genvar i;
  generate
    for (i = 1; i < DEPTH; i++) begin : g_stage
      assign line_n[i] = line_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        line_q <= '0;
    else if (shift) line_q <= line_n;
  end

  assign tap = line_n[sel];
endmodule

// File: rtl/pcg_pixclk_gen.sv
module pcg_pixclk_gen #(
  parameter int SPD_W = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div2,
  input  logic [SPD_W-1:0] speed,
  input  logic [DLY_W-1:0] delay,
  input  logic             stop,
  output logic             pclk_en,
  output logic             pclk_dly,
  output logic             launch_stb
);
  logic             step, bound, lvl_next, tap;
  logic [DLY_W-1:0] dly_next, dly_cur;

  pcg_halfstep u_half (
    .clk(clk), .rst(rst), .div2(div2), .stop(stop), .step(step)
  );

  pcg_phase #(.SPD_W(SPD_W), .DLY_W(DLY_W)) u_phase (
    .clk(clk), .rst(rst), .step(step), .spd_in(speed), .dly_in(delay),
    .bound(bound), .lvl_next(lvl_next), .dly_next(dly_next), .dly_cur(dly_cur)
  );

  pcg_delay_line #(.DLY_W(DLY_W)) u_dline (
    .clk(clk), .rst(rst), .shift(step), .din(lvl_next), .sel(dly_next), .tap(tap)
  );

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      pclk_en    <= 1'b0;
      pclk_dly   <= 1'b0;
      launch_stb <= 1'b0;
    end else if (step) begin
      pclk_en    <= tap & ~pclk_dly;
      pclk_dly   <= tap;
      launch_stb <= bound;
    end else begin
      pclk_en    <= 1'b0;
      launch_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/pcg_pixclk_gen_chk.sv
module pcg_pixclk_gen_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             stop,
  input logic             pclk_en,
  input logic             pclk_dly,
  input logic             launch_stb,
  input logic [DLY_W-1:0] dly_cur
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!launch_stb && !pclk_dly && !pclk_en)); // R1
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst) launch_stb |=> !launch_stb); // R2
  AST_ZERO_DLY_ALIGN: assert property (@(posedge clk) disable iff (rst) (launch_stb && dly_cur == '0) |-> pclk_dly); // R4
  AST_EN_ON_RISE: assert property (@(posedge clk) disable iff (rst) pclk_en |-> (pclk_dly && !$past(pclk_dly))); // R5
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (rst) stop |=> (!launch_stb && !pclk_dly && !pclk_en)); // R7
endmodule

bind pcg_pixclk_gen pcg_pixclk_gen_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .stop(stop), .pclk_en(pclk_en), .pclk_dly(pclk_dly),
  .launch_stb(launch_stb), .dly_cur(dly_cur)
);

// File: tb/pcg_pixclk_gen_tb.sv
module pcg_pixclk_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, div2 = 1'b0, stop = 1'b0;
  logic [3:0] speed = 4'd1, delay = 4'd1;
  logic pclk_en, pclk_dly, launch_stb;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcg_pixclk_gen dut_i (
    .clk(clk), .rst(rst), .div2(div2), .speed(speed), .delay(delay), .stop(stop),
    .pclk_en(pclk_en), .pclk_dly(pclk_dly), .launch_stb(launch_stb)
  );

  // reference state, built from the requirements
  bit m_pend, m_tog, e_l, e_p, e_e;
  int m_ph, m_s, m_d;
  bit [15:0] m_hist;
  bit model_on = 1'b1;

  function automatic int coerce(input int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit stp, b, lv, np;
    if (rst) begin
      m_pend = 1; m_ph = 0; m_s = 1; m_d = 1; m_hist = '0; m_tog = 0;
      e_l = 0; e_p = 0; e_e = 0;
    end else if (stop) begin
      e_l = 0; e_p = 0; e_e = 0;
    end else begin
      stp = div2 ? m_tog : 1'b1;
      m_tog = div2 ? ~m_tog : 1'b0;
      if (stp) begin
        b = m_pend || (m_ph == 2 * m_s - 1);
        if (b) begin m_ph = 0; m_s = coerce(speed); m_d = delay; m_pend = 0; end
        else m_ph++;
        lv = (m_ph < m_s);
        m_hist = {m_hist[14:0], lv};
        np = m_hist[m_d];
        e_e = np & ~e_p; e_p = np; e_l = b;
      end else begin
        e_l = 0; e_e = 0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    if (model_on) begin
      check("R2 launch_stb", launch_stb, e_l);
      check("R4 pclk_dly", pclk_dly, e_p);
      check("R5 pclk_en", pclk_en, e_e);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // cycles from one launch strobe to the next
  task automatic gap(output int g);
    int n = 0;
    while (!launch_stb && n < 200) begin tick(); n++; end
    g = 0;
    do begin tick(); g++; end while (!launch_stb && g < 200);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int g, hi;
    void'($urandom(32'd7));
    ticks(3);
    check("R1 reset launch", launch_stb, 0);
    check("R1 reset pclk", pclk_dly, 0);
    rst = 0; delay = 4'd0; speed = 4'd2;
    tick();
    check("R1 first launch", launch_stb, 1);
    check("R4 zero delay aligned", pclk_dly, 1);
    ticks(10);

    speed = 4'd0; ticks(8); gap(g); check("R3 speed0 gap", g, 2);
    speed = 4'd1; gap(g); check("R3 speed1 gap", g, 2);
    speed = 4'd3; ticks(8); gap(g); check("R2 speed3 gap", g, 6);

    div2 = 1; ticks(16); gap(g); check("R6 div2 gap", g, 12);
    div2 = 0; ticks(16);

    // R4: lag measured from launch to pclk rise
    speed = 4'd5; delay = 4'd3; ticks(24);
    while (!launch_stb) tick();
    g = 0;
    while (!pclk_en && g < 50) begin tick(); g++; end
    check("R4 lag of 3", g, 3);
    hi = 0;
    while (pclk_dly && hi < 50) begin tick(); hi++; end
    check("R4 high width", hi, 5);

    // R8: mid-period change keeps current period
    speed = 4'd4; delay = 4'd0; ticks(20);
    while (!launch_stb) tick();
    ticks(2);
    speed = 4'd2;
    g = 2;
    do begin tick(); g++; end while (!launch_stb && g < 50);
    check("R8 old period kept", g, 8);
    gap(g); check("R8 new period", g, 4);

    // R7: stop holds outputs, resume continues
    stop = 1; tick();
    hi = 0;
    for (int i = 0; i < 6; i++) begin tick(); hi += launch_stb + pclk_dly + pclk_en; end
    check("R7 outputs off", hi, 0);
    stop = 0; ticks(12);

    // random phase with per-cycle comparison
    for (int k = 0; k < 60; k++) begin
      speed = 4'($urandom_range(0, 15));
      delay = 4'($urandom_range(0, 15));
      div2  = ($urandom_range(0, 3) == 0);
      stop  = ($urandom_range(0, 7) == 0);
      ticks($urandom_range(5, 60));
      stop = 0;
    end
    rst = 1; tick(); tick();
    check("R1 reset again", launch_stb + pclk_dly + pclk_en, 0);
    rst = 0; ticks(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule